// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the word-addressed register file that a processor core module exposes for board-level control and identification. Software reads fixed identity and status words. It programs two clock-oscillator words, but only after writing a 16-bit unlock key. It also sets the memory-remap selection and requests a system reset through a control word, and keeps general-purpose and non-volatile flag words that have separate set and clear addresses.

The block also exposes a 32-bit reference counter that advances at a fixed reference rate derived from the bus clock by a fractional prescaler. A read-only window returns the bytes of a small memory presence table. A local interrupt source made of one software interrupt bit, with separate IRQ and FIQ enable words, drives two interrupt outputs. Reads are combinational from the address. A write takes effect on the rising clock edge on which the write enable is high.

Top module: `coremod_sysctl`

## Requirements
- R1: The word at byte offset 0x00 reads 0x411A3001, offset 0x04 reads 0 and offset 0x10 reads 0x00100000. Every word that is not listed in R2 to R11 (word 11, words 13 and 15 on read, words 32 to 63 and anything at or above offset 0x200) reads 0 and ignores writes, as do the read-only words.
- R2: A write to offset 0x14 stores data bits [15:0]. A read returns the stored key in bits [15:0] and sets bit 16 exactly when the stored key is 0xA05F.
- R3: Writes to the oscillator word (0x08) and the auxiliary oscillator word (0x1C) change them only while the stored key equals 0xA05F. Otherwise the old value is kept.
- R4: A write to the control word (0x0C) keeps only data bits 0 and 2, and a read shows those two bits with bit 3 always 0. The output `remapRam` equals the stored bit 2.
- R5: A write to 0x0C with data bit 3 set raises `resetReq` for exactly the one cycle after that write edge.
- R6: Writing 0x30 ORs the data into the flag word and writing 0x34 clears the bits written as one; the flag word reads at 0x30. The non-volatile flags behave the same way at 0x38 (set and read) and 0x3C (clear).
- R7: After reset the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, the init word (0x24) 0x00000112 and the SDRAM word (0x20) 0x00011122 ORed with a size code: 0x10 for 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, otherwise 0. With the default 128 MB this gives 0x0001112E. The SDRAM and init words take any written value.
- R8: The word at offset 0x100 + 4*i (i from 0 to 31) reads presence byte i in bits [7:0]. Offsets 0x180 to 0x1FF read 0. Byte 31 is the density: 64, 32, 16, 4 or 2 for the same size thresholds as R7.
- R9: Offset 0x28 reads a count that is floor(n*REF_NUM/REF_DEN) after n clock edges since reset was released. By default this is 24/50, a 24 MHz count from a 50 MHz bus clock.
- R10: The IRQ enable word is set at 0x48 (which also reads it) and cleared at 0x4C. The raw level reads at 0x44 and the level ANDed with the enables reads at 0x40. The FIQ set is 0x68, 0x6C, 0x64 and 0x60 in the same roles. `irqOut` and `fiqOut` are high when any enabled level bit is set.
- R11: Writing data bit 0 as one to 0x50 sets the software interrupt level, and writing it to 0x54 clears it. Other data bits have no effect, and 0x50 reads the level in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | ADDR_W | Byte offset; bits [ADDR_W-1:2] select the word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| remapRam | output | 1 | High selects RAM at address zero, low selects boot flash |
| resetReq | output | 1 | One-cycle system reset request |
| irqOut | output | 1 | Local IRQ request |
| fiqOut | output | 1 | Local FIQ request |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- the decode never raises two write strobes at once;
- the oscillator word cannot move while the key is absent;
- the remap output changes only on a control write;
- a reset request always follows a control write with bit 3 set;
- cleared flag bits read zero;
- the reference counter never jumps by more than one.

Only the bench's scenarios can show:
- the exact read values of each word;
- the fixed presence table contents and the size-dependent reset values;
- the count matching the fractional rate over hundreds of cycles;
- that writes to unmapped and read-only words leave every register unchanged.

// File: rtl/coremod_pkg.sv
package coremod_pkg;

  localparam logic [31:0] ID_WORD     = 32'h411A3001;
  localparam logic [31:0] STAT_WORD   = 32'h00100000;
  localparam logic [31:0] OSC_RST     = 32'h01000048;
  localparam logic [31:0] AUX_RST     = 32'h0007FEFF;
  localparam logic [31:0] SDRAM_BASE  = 32'h00011122;
  localparam logic [31:0] INIT_RST    = 32'h00000112;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;

  localparam int SPD_BASE_WORD = 64;
  localparam int SPD_IDX_W     = 5;
  localparam int SPD_WORDS     = 1 << SPD_IDX_W;

  typedef struct packed {
    logic wrOsc;
    logic wrAux;
    logic wrCtrl;
    logic wrLock;
    logic wrSdram;
    logic wrInit;
    logic setFlags;
    logic clrFlags;
    logic setNv;
    logic clrNv;
    logic setIrqEn;
    logic clrIrqEn;
    logic setFiqEn;
    logic clrFiqEn;
    logic setSoft;
    logic clrSoft;
  } wrStrobeT;

  typedef enum logic [4:0] {
    RD_ZERO, RD_ID, RD_OSC, RD_CTRL, RD_STAT, RD_LOCK, RD_AUX, RD_SDRAM,
    RD_INIT, RD_REF, RD_FLAGS, RD_NV, RD_IRQST, RD_RAW, RD_IRQEN, RD_SOFT,
    RD_FIQST, RD_FIQEN, RD_SPD
  } rdSelT;

  function automatic logic [31:0] sdramSizeCode(int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] presenceByte(logic [SPD_IDX_W-1:0] idx, int mb);
    case (idx)
      5'd0:  return 8'd128;
      5'd1:  return 8'd8;
      5'd2:  return 8'd4;
      5'd3:  return 8'd11;
      5'd4:  return 8'd9;
      5'd5:  return 8'd1;
      5'd6:  return 8'd64;
      5'd8:  return 8'd2;
      5'd9:  return 8'hA0;
      5'd10: return 8'hA0;
      5'd13: return 8'd8;
      5'd15: return 8'd1;
      5'd16: return 8'h0E;
      5'd17: return 8'd4;
      5'd18: return 8'h1C;
      5'd19: return 8'd1;
      5'd20: return 8'd2;
      5'd21: return 8'h20;
      5'd22: return 8'hC0;
      5'd27: return 8'h30;
      5'd28: return 8'h28;
      5'd29: return 8'h30;
      5'd30: return 8'h28;
      5'd31: begin
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
      end
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/coremod_decode.sv
module coremod_decode
  import coremod_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 unlocked,
  output wrStrobeT             stb,
  output rdSelT                rdSel,
  output logic [SPD_IDX_W-1:0] spdIdx
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  int                wordNum;

  assign wordIdx = addr[ADDR_W-1:2];
  assign wordNum = int'(wordIdx);
  assign spdIdx  = wordIdx[SPD_IDX_W-1:0];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wordNum)
        2:  stb.wrOsc    = unlocked;
        3:  stb.wrCtrl   = 1'b1;
        5:  stb.wrLock   = 1'b1;
        7:  stb.wrAux    = unlocked;
        8:  stb.wrSdram  = 1'b1;
        9:  stb.wrInit   = 1'b1;
        12: stb.setFlags = 1'b1;
        13: stb.clrFlags = 1'b1;
        14: stb.setNv    = 1'b1;
        15: stb.clrNv    = 1'b1;
        18: stb.setIrqEn = 1'b1;
        19: stb.clrIrqEn = 1'b1;
        20: stb.setSoft  = 1'b1;
        21: stb.clrSoft  = 1'b1;
        26: stb.setFiqEn = 1'b1;
        27: stb.clrFiqEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (wordNum >= SPD_BASE_WORD && wordNum < SPD_BASE_WORD + SPD_WORDS) begin
      rdSel = RD_SPD;
    end else begin
      case (wordNum)
        0:  rdSel = RD_ID;
        2:  rdSel = RD_OSC;
        3:  rdSel = RD_CTRL;
        4:  rdSel = RD_STAT;
        5:  rdSel = RD_LOCK;
        7:  rdSel = RD_AUX;
        8:  rdSel = RD_SDRAM;
        9:  rdSel = RD_INIT;
        10: rdSel = RD_REF;
        12: rdSel = RD_FLAGS;
        14: rdSel = RD_NV;
        16: rdSel = RD_IRQST;
        17: rdSel = RD_RAW;
        18: rdSel = RD_IRQEN;
        20: rdSel = RD_SOFT;
        24: rdSel = RD_FIQST;
        25: rdSel = RD_RAW;
        26: rdSel = RD_FIQEN;
        default: rdSel = RD_ZERO;
      endcase
    end
  end

  // R1: a single bus write never touches two registers
  always_comb begin
    a_r1_one_strobe: assert ($onehot0(stb));
  end

endmodule

// File: rtl/coremod_regs.sv
module coremod_regs
  import coremod_pkg::*;
#(
  parameter int MEM_MB  = 128,
  parameter int REF_NUM = 24,
  parameter int REF_DEN = 50
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobeT             stb,
  input  rdSelT                rdSel,
  input  logic [SPD_IDX_W-1:0] spdIdx,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 unlocked,
  output logic                 remapRam,
  output logic                 resetReq,
  output logic                 irqOut,
  output logic                 fiqOut
);

  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdramSizeCode(MEM_MB);
  localparam int          ACC_W     = $clog2(REF_DEN + REF_NUM + 1);

  logic [31:0] oscReg, auxReg, sdramReg, initReg, flagsReg, nvReg;
  logic [31:0] irqEn, fiqEn, refCnt;
  logic [15:0] lockReg;
  logic        ledBit, softLvl;

  assign unlocked = (lockReg == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscReg   <= OSC_RST;
      auxReg   <= AUX_RST;
      sdramReg <= SDRAM_RST;
      initReg  <= INIT_RST;
      flagsReg <= '0;
      nvReg    <= '0;
      irqEn    <= '0;
      fiqEn    <= '0;
      lockReg  <= '0;
      ledBit   <= 1'b0;
      remapRam <= 1'b0;
      softLvl  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= stb.wrCtrl & wrData[3];
      if (stb.wrOsc)   oscReg   <= wrData;
      if (stb.wrAux)   auxReg   <= wrData;
      if (stb.wrSdram) sdramReg <= wrData;
      if (stb.wrInit)  initReg  <= wrData;
      if (stb.wrLock)  lockReg  <= wrData[15:0];
      if (stb.wrCtrl) begin
        ledBit   <= wrData[0];
        remapRam <= wrData[2];
      end
      if (stb.setFlags) flagsReg <= flagsReg | wrData;
      if (stb.clrFlags) flagsReg <= flagsReg & ~wrData;
      if (stb.setNv)    nvReg    <= nvReg | wrData;
      if (stb.clrNv)    nvReg    <= nvReg & ~wrData;
      if (stb.setIrqEn) irqEn    <= irqEn | wrData;
      if (stb.clrIrqEn) irqEn    <= irqEn & ~wrData;
      if (stb.setFiqEn) fiqEn    <= fiqEn | wrData;
      if (stb.clrFiqEn) fiqEn    <= fiqEn & ~wrData;
      if (stb.setSoft && wrData[0]) softLvl <= 1'b1;
      if (stb.clrSoft && wrData[0]) softLvl <= 1'b0;
    end
  end

  generate
    if (REF_NUM >= REF_DEN) begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) refCnt <= '0;
        else       refCnt <= refCnt + 32'd1;
      end
    end else begin : g_frac
      logic [ACC_W-1:0] refAcc, accSum;
      assign accSum = refAcc + ACC_W'(REF_NUM);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          refAcc <= '0;
          refCnt <= '0;
        end else if (accSum >= ACC_W'(REF_DEN)) begin
          refAcc <= accSum - ACC_W'(REF_DEN);
          refCnt <= refCnt + 32'd1;
        end else begin
          refAcc <= accSum;
        end
      end
    end
  endgenerate

  logic irqHit, fiqHit;
  assign irqHit = softLvl & irqEn[0];
  assign fiqHit = softLvl & fiqEn[0];
  assign irqOut = irqHit;
  assign fiqOut = fiqHit;

  always_comb begin
    case (rdSel)
      RD_ID:    rdData = ID_WORD;
      RD_OSC:   rdData = oscReg;
      RD_CTRL:  rdData = {29'd0, remapRam, 1'b0, ledBit};
      RD_STAT:  rdData = STAT_WORD;
      RD_LOCK:  rdData = {15'd0, unlocked, lockReg};
      RD_AUX:   rdData = auxReg;
      RD_SDRAM: rdData = sdramReg;
      RD_INIT:  rdData = initReg;
      RD_REF:   rdData = refCnt;
      RD_FLAGS: rdData = flagsReg;
      RD_NV:    rdData = nvReg;
      RD_IRQST: rdData = {31'd0, irqHit};
      RD_RAW:   rdData = {31'd0, softLvl};
      RD_IRQEN: rdData = irqEn;
      RD_SOFT:  rdData = {31'd0, softLvl};
      RD_FIQST: rdData = {31'd0, fiqHit};
      RD_FIQEN: rdData = fiqEn;
      RD_SPD:   rdData = {24'd0, presenceByte(spdIdx, MEM_MB)};
      default:  rdData = '0;
    endcase
  end

  // R3: without the key the oscillator word holds its value
  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(oscReg));

  // R4: remap output moves only on a control write
  a_r4_remap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCtrl |=> $stable(remapRam));

  // R5: a reset request always comes from a control write with bit 3
  a_r5_req_source: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(stb.wrCtrl && wrData[3]));

  // R6: bits written to the clear address read back as zero
  a_r6_clear_flags: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrFlags |=> ((flagsReg & $past(wrData)) == 32'd0));

  // R9: the reference count advances by at most one per edge
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (refCnt == $past(refCnt) || refCnt == $past(refCnt) + 32'd1));

endmodule

// File: rtl/coremod_sysctl.sv
module coremod_sysctl
  import coremod_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MEM_MB  = 128,
  parameter int REF_NUM = 24,
  parameter int REF_DEN = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              remapRam,
  output logic              resetReq,
  output logic              irqOut,
  output logic              fiqOut
);

  wrStrobeT             stb;
  rdSelT                rdSel;
  logic [SPD_IDX_W-1:0] spdIdx;
  logic                 unlocked;

  coremod_decode #(.ADDR_W(ADDR_W)) decode_i (
    .wrEn     (wrEn),
    .addr     (addr),
    .unlocked (unlocked),
    .stb      (stb),
    .rdSel    (rdSel),
    .spdIdx   (spdIdx)
  );

  coremod_regs #(
    .MEM_MB  (MEM_MB),
    .REF_NUM (REF_NUM),
    .REF_DEN (REF_DEN)
  ) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .spdIdx   (spdIdx),
    .wrData   (wrData),
    .rdData   (rdData),
    .unlocked (unlocked),
    .remapRam (remapRam),
    .resetReq (resetReq),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

endmodule

// File: tb/coremod_sysctl_tb_top.sv
module coremod_sysctl_tb_top;

  localparam int CLK_P = 10;
  localparam int AW    = 12;
  localparam int MB    = 128;
  localparam int RN    = 24;
  localparam int RD    = 50;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          remapRam, resetReq, irqOut, fiqOut;

  always #(CLK_P/2) clk = ~clk;

  coremod_sysctl #(.ADDR_W(AW), .MEM_MB(MB), .REF_NUM(RN), .REF_DEN(RD)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .remapRam(remapRam), .resetReq(resetReq),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // behavioural reference state
  logic [31:0] mOsc, mAux, mSdram, mInit, mFlags, mNv, mIrqEn, mFiqEn;
  logic [15:0] mLock;
  logic        mLed, mRemap, mSoft, mRst;
  longint      mEdges;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  function automatic logic [7:0] tableByte(int i);
    logic [7:0] t [32] = '{128, 8, 4, 11, 9, 1, 64, 0, 2, 8'hA0, 8'hA0, 0, 0, 8, 0, 1,
                           8'h0E, 4, 8'h1C, 1, 2, 8'h20, 8'hC0, 0, 0, 0, 0,
                           8'h30, 8'h28, 8'h30, 8'h28, 32};
    return t[i];
  endfunction

  function automatic logic [31:0] modelRead(logic [AW-1:0] a);
    int w = int'(a[AW-1:2]);
    if (w >= 64 && w < 96) return {24'd0, tableByte(w - 64)};
    case (w)
      0:  return 32'h411A3001;
      2:  return mOsc;
      3:  return {29'd0, mRemap, 1'b0, mLed};
      4:  return 32'h00100000;
      5:  return {15'd0, (mLock == 16'hA05F), mLock};
      7:  return mAux;
      8:  return mSdram;
      9:  return mInit;
      10: return 32'(mEdges * RN / RD);
      12: return mFlags;
      14: return mNv;
      16: return {31'd0, mSoft & mIrqEn[0]};
      17: return {31'd0, mSoft};
      18: return mIrqEn;
      20: return {31'd0, mSoft};
      24: return {31'd0, mSoft & mFiqEn[0]};
      25: return {31'd0, mSoft};
      26: return mFiqEn;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(logic [AW-1:0] a);
    int w = int'(a[AW-1:2]);
    if (w >= 64 && w < 128) return "R8";
    case (w)
      5:  return "R2";
      2, 7: return "R3";
      3:  return "R4";
      12, 14: return "R6";
      8, 9: return "R7";
      10: return "R9";
      16, 17, 18, 24, 25, 26: return "R10";
      20: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mOsc = 32'h01000048; mAux = 32'h0007FEFF; mSdram = 32'h0001112E;
      mInit = 32'h00000112; mFlags = '0; mNv = '0; mIrqEn = '0; mFiqEn = '0;
      mLock = '0; mLed = 0; mRemap = 0; mSoft = 0; mRst = 0; mEdges = 0;
    end else begin
      mEdges++;
      mRst = 1'b0;
      if (wrEn) begin
        case (int'(addr[AW-1:2]))
          2:  if (mLock == 16'hA05F) mOsc = wrData;
          3:  begin mLed = wrData[0]; mRemap = wrData[2]; mRst = wrData[3]; end
          5:  mLock = wrData[15:0];
          7:  if (mLock == 16'hA05F) mAux = wrData;
          8:  mSdram = wrData;
          9:  mInit = wrData;
          12: mFlags = mFlags | wrData;
          13: mFlags = mFlags & ~wrData;
          14: mNv = mNv | wrData;
          15: mNv = mNv & ~wrData;
          18: mIrqEn = mIrqEn | wrData;
          19: mIrqEn = mIrqEn & ~wrData;
          20: if (wrData[0]) mSoft = 1'b1;
          21: if (wrData[0]) mSoft = 1'b0;
          26: mFiqEn = mFiqEn | wrData;
          27: mFiqEn = mFiqEn & ~wrData;
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk(reqOf(addr), "rdData", rdData, modelRead(addr));
      chk("R4", "remapRam", 32'(remapRam), 32'(mRemap));
      chk("R5", "resetReq", 32'(resetReq), 32'(mRst));
      chk("R10", "irqOut", 32'(irqOut), 32'(mSoft & mIrqEn[0]));
      chk("R10", "fiqOut", 32'(fiqOut), 32'(mSoft & mFiqEn[0]));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk);
    addr = a; wrEn = 1'b0;
  endtask

  task automatic sweep();
    for (int w = 0; w < 41; w++) rd(AW'(w * 4));
    for (int a = 'h100; a < 'h200; a += 4) rd(AW'(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 R7 R8: reset state of every word and the presence window
    sweep();
    // R3: locked oscillator writes ignored
    wr(12'h008, 32'h12345678); rd(12'h008);
    wr(12'h01C, 32'h87654321); rd(12'h01C);
    // R2 R3: unlock, program, relock
    wr(12'h014, 32'hBEEFA05F); rd(12'h014);
    wr(12'h008, 32'hCAFE0001); wr(12'h01C, 32'h0000AA55);
    rd(12'h008); rd(12'h01C);
    wr(12'h014, 32'h00001111); rd(12'h014);
    wr(12'h008, 32'h0); rd(12'h008);
    // R4 R5: control bits, reset pulse
    wr(12'h00C, 32'hFFFFFFFF); rd(12'h00C);
    wr(12'h00C, 32'h00000001); rd(12'h00C);
    wr(12'h00C, 32'h00000008); rd(12'h00C);
    // R6: flags and non-volatile flags
    wr(12'h030, 32'h0000F0F0); wr(12'h030, 32'h00000F00);
    wr(12'h034, 32'h000000F0); rd(12'h030);
    wr(12'h038, 32'hA5A50000); wr(12'h03C, 32'h05000000); rd(12'h038);
    // R7: plain writable words
    wr(12'h020, 32'h0000DEAD); wr(12'h024, 32'h00000077);
    rd(12'h020); rd(12'h024);
    // R10 R11: enables and software interrupt
    wr(12'h048, 32'h000000FF); wr(12'h050, 32'h00000003);
    rd(12'h040); rd(12'h044); rd(12'h050);
    wr(12'h04C, 32'h00000001); rd(12'h040); rd(12'h048);
    wr(12'h068, 32'h00000001); rd(12'h060); rd(12'h064); rd(12'h068);
    wr(12'h054, 32'h00000002); rd(12'h050);
    wr(12'h06C, 32'h00000001); rd(12'h060);
    wr(12'h048, 32'h00000001); wr(12'h054, 32'h00000001); rd(12'h050);
    // R1: writes to unmapped and read-only words change nothing
    wr(12'h02C, 32'hFFFFFFFF); wr(12'h080, 32'hFFFFFFFF);
    wr(12'h100, 32'hFFFFFFFF); wr(12'h000, 32'hFFFFFFFF);
    wr(12'h040, 32'hFFFFFFFF); wr(12'h1FC, 32'hFFFFFFFF);
    sweep();
    // R9: reference counter over a long idle stretch
    rd(12'h028);
    repeat (300) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule